// File: doc/BRIEF.md
# Deadline-mode local timer

This block is a local interrupt timer that fires at an absolute point in time. It does not count down. Software first programs a timer entry register. That register holds a two-bit mode field, a mask bit and an 8-bit interrupt vector. Software then writes a target time into a deadline register. The block compares that target against a free-running time-stamp counter supplied from outside. When the counter is at or beyond the target, the block clears the deadline and raises an interrupt request carrying the programmed vector.

A deadline already in the past fires straight away; there is no wait for a counter wrap. A zero deadline means the timer is disarmed. Each armed deadline yields one request at most. The request is held until a single-cycle acknowledge arrives. The register port is a plain single-cycle write strobe with a combinational read mux. The same port also lets software read the counter.

Top module: `dl_timer`

## Requirements
- R1: The timer entry register sits at address 0x0A0. Bits 7:0 hold the vector, bit 16 is the mask, and bits 18:17 are the mode field, where the value 2 selects deadline mode. Every other bit reads back as 0. After reset the whole entry is 0.
- R2: Suppose a deadline write is accepted on clock edge k and the written value is nonzero and less than or equal to the counter. Then `irq_req_o` is high after edge k+1.
- R3: Suppose an armed deadline is above the counter. Then `irq_req_o` stays low until the counter input reaches the deadline. It rises after the first clock edge at which the counter is sampled at or beyond the deadline.
- R4: Once the deadline expires, the deadline register (address 0x6E0) reads 0.
- R5: Each armed deadline produces exactly one request. Once it is acknowledged, no further request follows, however long the counter stays past the old deadline.
- R6: The request carries on `irq_vec_o` the vector held in entry bits 7:0 at the moment of expiry.
- R7: Writing 0 to the deadline register disarms the timer, and no request is raised.
- R8: When entry bit 16 is set, an expiry still clears the deadline but raises no request.
- R9: While the mode field is not 2, writes to the deadline register are ignored and the register reads 0. Writing the entry with a mode other than 2 drops any armed deadline.
- R10: Once raised, `irq_req_o` stays high, with its vector held, until `ack_i` is high on a clock edge. After that edge it is low.
- R11: Address 0x010 reads the current counter input. Address 0x6E0 reads the armed deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register address |
| wdata_i | input | 64 | Register write data |
| rdata_o | output | 64 | Register read data, combinational from addr_i |
| tsc_i | input | 64 | Free-running time-stamp counter |
| ack_i | input | 1 | Single-cycle acknowledge of the request |
| irq_req_o | output | 1 | Interrupt request |
| irq_vec_o | output | 8 | Vector carried by the request |

## Verification
The bench builds the block with its default parameters. These are a 64-bit counter and deadline, a 12-bit address and the three default register addresses. The bench drives the counter input itself rather than taking it from the block. It can therefore freeze the counter, or jump it to any value in one cycle. That puts in reach past deadlines, deadlines exactly one tick ahead, and long stretches of time after an expiry, all within a few cycles of the run.

// File: rtl/dlt_pkg.sv
package dlt_pkg;
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned MASK_BIT  = 16;
  localparam int unsigned MODE_LSB  = 17;
  localparam logic [1:0]  MODE_DLINE = 2'd2;

  typedef struct packed {
    logic [1:0]       mode;
    logic             mask;
    logic [VEC_W-1:0] vec;
  } entry_t;
endpackage

// File: rtl/dlt_cmp.sv
module dlt_cmp #(
  parameter int unsigned TS_W = 64
) (
  input  logic [TS_W-1:0] dl_i,
  input  logic [TS_W-1:0] tsc_i,
  output logic            expire_o
);
  // zero deadline means disarmed
  assign expire_o = (dl_i != '0) && (tsc_i >= dl_i);
endmodule

// File: rtl/dlt_regs.sv
module dlt_regs
  import dlt_pkg::*;
#(
  parameter int unsigned TS_W       = 64,
  parameter int unsigned ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] ENTRY_ADDR = 12'h0A0,
  parameter logic [ADDR_W-1:0] DL_ADDR    = 12'h6E0,
  parameter logic [ADDR_W-1:0] TSC_ADDR   = 12'h010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TS_W-1:0]   wdata_i,
  input  logic [TS_W-1:0]   tsc_i,
  input  logic              expire_i,
  output entry_t            entry_o,
  output logic [TS_W-1:0]   dl_o,
  output logic              dl_wr_o,
  output logic [TS_W-1:0]   rdata_o
);
  localparam int unsigned MODE_MSB = MODE_LSB + 1;

  entry_t          entry_q;
  logic [TS_W-1:0] dl_q;
  logic            entry_wr;
  logic            dline_mode;
  entry_t          entry_new;

  assign dline_mode = (entry_q.mode == MODE_DLINE);
  assign entry_wr   = we_i && (addr_i == ENTRY_ADDR);
  assign dl_wr_o    = we_i && (addr_i == DL_ADDR) && dline_mode;

  assign entry_new.mode = wdata_i[MODE_MSB:MODE_LSB];
  assign entry_new.mask = wdata_i[MASK_BIT];
  assign entry_new.vec  = wdata_i[VEC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= '0;
    end else if (entry_wr) begin
      entry_q <= entry_new;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dl_q <= '0;
    end else if (entry_wr && (entry_new.mode != MODE_DLINE)) begin
      dl_q <= '0;
    end else if (dl_wr_o) begin
      dl_q <= wdata_i;
    end else if (expire_i) begin
      dl_q <= '0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ENTRY_ADDR) begin
      rdata_o[MODE_MSB:MODE_LSB] = entry_q.mode;
      rdata_o[MASK_BIT]          = entry_q.mask;
      rdata_o[VEC_W-1:0]         = entry_q.vec;
    end else if (addr_i == DL_ADDR) begin
      rdata_o = dline_mode ? dl_q : '0;
    end else if (addr_i == TSC_ADDR) begin
      rdata_o = tsc_i;
    end
  end

  assign entry_o = entry_q;
  assign dl_o    = dl_q;
endmodule

// File: rtl/dlt_irq.sv
module dlt_irq #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             mask_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o
);
  logic             req_q;
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else if (fire_i && !mask_i) begin
      req_q <= 1'b1;
      vec_q <= vec_i;
    end else if (ack_i) begin
      req_q <= 1'b0;
    end
  end

  assign req_o = req_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/dl_timer.sv
module dl_timer
  import dlt_pkg::*;
#(
  parameter int unsigned TS_W   = 64,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ENTRY_ADDR = 12'h0A0,
  parameter logic [ADDR_W-1:0] DL_ADDR    = 12'h6E0,
  parameter logic [ADDR_W-1:0] TSC_ADDR   = 12'h010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TS_W-1:0]   wdata_i,
  output logic [TS_W-1:0]   rdata_o,
  input  logic [TS_W-1:0]   tsc_i,
  input  logic              ack_i,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  entry_t           entry_w;
  logic [TS_W-1:0]  dl_w;
  logic             dl_wr_w;
  logic             expire_w;
  logic             fire_w;
  logic [1:0]       mode_w;
  logic             mask_w;
  logic [VEC_W-1:0] vec_w;

  assign mode_w = entry_w.mode;
  assign mask_w = entry_w.mask;
  assign vec_w  = entry_w.vec;
  // a fresh deadline write replaces the old one
  assign fire_w = expire_w && !dl_wr_w;

  dlt_regs #(
    .TS_W(TS_W), .ADDR_W(ADDR_W),
    .ENTRY_ADDR(ENTRY_ADDR), .DL_ADDR(DL_ADDR), .TSC_ADDR(TSC_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .tsc_i(tsc_i), .expire_i(expire_w),
    .entry_o(entry_w), .dl_o(dl_w), .dl_wr_o(dl_wr_w), .rdata_o(rdata_o)
  );

  dlt_cmp #(.TS_W(TS_W)) u_cmp (
    .dl_i(dl_w), .tsc_i(tsc_i), .expire_o(expire_w)
  );

  dlt_irq #(.VEC_W(VEC_W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire_w), .mask_i(mask_w),
    .vec_i(vec_w), .ack_i(ack_i), .req_o(irq_req_o), .vec_o(irq_vec_o)
  );
endmodule

// File: rtl/dlt_checker.sv
module dlt_checker #(
  parameter int unsigned TS_W  = 64,
  parameter int unsigned VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_i,
  input logic             irq_req_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic [1:0]       mode_w,
  input logic             mask_w,
  input logic [VEC_W-1:0] vec_w,
  input logic [TS_W-1:0]  dl_w,
  input logic [TS_W-1:0]  tsc_i,
  input logic             dl_wr_w
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o && !ack_i |=> irq_req_o && $stable(irq_vec_o)); // R10
  AST_DL_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_req_o) |-> dl_w == '0); // R4
  AST_OFF_MODE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_w != 2'd2 |-> dl_w == '0); // R9
  AST_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_req_o) |-> !$past(mask_w)); // R8
  AST_VEC_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_req_o) |-> irq_vec_o == $past(vec_w)); // R6
  AST_EXPIRY_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dl_w != '0) && (tsc_i >= dl_w) && !mask_w && !dl_wr_w |=> irq_req_o); // R3
endmodule

bind dl_timer dlt_checker #(.TS_W(TS_W), .VEC_W(dlt_pkg::VEC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .irq_req_o(irq_req_o),
  .irq_vec_o(irq_vec_o), .mode_w(mode_w), .mask_w(mask_w), .vec_w(vec_w),
  .dl_w(dl_w), .tsc_i(tsc_i), .dl_wr_w(dl_wr_w)
);

// File: tb/dl_timer_bench.sv
module dl_timer_bench;
  localparam int CLK_PER = 10;
  localparam logic [11:0] A_ENT = 12'h0A0;
  localparam logic [11:0] A_DL  = 12'h6E0;
  localparam logic [11:0] A_TSC = 12'h010;
  localparam logic [63:0] MODE2 = 64'h4_0000; // mode 2 at bits 18:17
  localparam logic [63:0] MASKB = 64'h1_0000; // bit 16

  logic clk = 1'b0, rst_ni = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [63:0] wdata_i = '0, rdata_o, tsc = '0, tsc_val = '0;
  logic tsc_run = 1'b0, tsc_set = 1'b0;
  logic ack_auto = 1'b0, ack_man = 1'b0, auto_ack = 1'b0;
  logic irq_req_o;
  logic [7:0] irq_vec_o;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk)
    if (tsc_set) tsc <= tsc_val;
    else if (tsc_run) tsc <= tsc + 64'd1;

  dl_timer u_dl_timer (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tsc_i(tsc),
    .ack_i(ack_auto | ack_man), .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string msg);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] v);
    addr_i = a; #1; v = rdata_o;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_tsc(input logic [63:0] v);
    tsc_val = v; tsc_set = 1'b1;
    @(negedge clk);
    tsc_set = 1'b0;
  endtask

  task automatic man_ack();
    ack_man = 1'b1;
    @(negedge clk);
    ack_man = 1'b0;
  endtask

  // monitor: pops expected vectors as requests appear and acknowledges them
  initial begin
    forever begin
      @(negedge clk);
      if (ack_auto) ack_auto = 1'b0;
      else if (auto_ack && irq_req_o) begin
        if (exp_q.size() == 0) chk(1, 0, "R5 unexpected request");
        else chk({56'd0, irq_vec_o}, {56'd0, exp_q.pop_front()}, "R6 vector");
        ack_auto = 1'b1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    // reset state
    chk({63'd0, irq_req_o}, 0, "R10 reset request");
    rd(A_ENT, v); chk(v, 0, "R1 reset entry");
    rd(A_DL, v);  chk(v, 0, "R9 reset deadline");
    set_tsc(64'd1000);
    rd(A_TSC, v); chk(v, 64'd1000, "R11 counter read");

    // R9: mode 0, deadline write ignored
    wr(A_DL, 64'd50);
    rd(A_DL, v); chk(v, 0, "R9 write ignored off mode");
    cyc(3); chk({63'd0, irq_req_o}, 0, "R9 no request off mode");

    // R1: field readback
    wr(A_ENT, 64'h8000_1000 | MODE2 | 64'hEF);
    rd(A_ENT, v); chk(v, MODE2 | 64'hEF, "R1 entry readback");

    // R2: past deadline fires two edges after write
    wr(A_DL, 64'd900);
    chk({63'd0, irq_req_o}, 0, "R2 request after one edge");
    cyc(1);
    chk({63'd0, irq_req_o}, 1, "R2 request after two edges");
    chk({56'd0, irq_vec_o}, 64'hEF, "R6 vector EF");
    rd(A_DL, v); chk(v, 0, "R4 deadline cleared");
    cyc(4); chk({63'd0, irq_req_o}, 1, "R10 held without ack");
    man_ack();
    chk({63'd0, irq_req_o}, 0, "R10 dropped after ack");
    cyc(10); chk({63'd0, irq_req_o}, 0, "R5 no second request");

    // R3: future deadline one tick ahead
    wr(A_DL, 64'd1001);
    rd(A_DL, v); chk(v, 64'd1001, "R11 deadline read");
    cyc(3); chk({63'd0, irq_req_o}, 0, "R3 quiet before deadline");
    set_tsc(64'd1001);
    chk({63'd0, irq_req_o}, 0, "R3 not yet at counter edge");
    cyc(1); chk({63'd0, irq_req_o}, 1, "R3 fires after deadline reached");
    man_ack();

    // R7: write 0 disarms
    wr(A_DL, 64'd2000);
    wr(A_DL, 64'd0);
    set_tsc(64'd5000);
    cyc(3); chk({63'd0, irq_req_o}, 0, "R7 zero disarms");

    // R8: masked expiry
    wr(A_ENT, MASKB | MODE2 | 64'h33);
    wr(A_DL, 64'd900);
    cyc(3);
    chk({63'd0, irq_req_o}, 0, "R8 masked no request");
    rd(A_DL, v); chk(v, 0, "R8 masked deadline cleared");

    // R9: leaving deadline mode drops armed deadline
    wr(A_ENT, MODE2 | 64'h44);
    wr(A_DL, 64'd9000);
    wr(A_ENT, 64'h2_0000 | 64'h44);
    rd(A_DL, v); chk(v, 0, "R9 mode switch reads 0");
    wr(A_ENT, MODE2 | 64'h44);
    rd(A_DL, v); chk(v, 0, "R9 deadline dropped");
    set_tsc(64'd10000);
    cyc(3); chk({63'd0, irq_req_o}, 0, "R9 dropped deadline silent");

    // scoreboard flow with running counter
    auto_ack = 1'b1; tsc_run = 1'b1;
    foreach (v[i]) if (i < 4) begin
      logic [7:0] vv;
      vv = 8'h20 + 8'(i * 8'h31);
      wr(A_ENT, MODE2 | {56'd0, vv});
      exp_q.push_back(vv);
      wr(A_DL, (i % 2 == 0) ? tsc + 64'd4 : tsc - 64'd3);
      for (int k = 0; k < 40 && exp_q.size() != 0; k++) cyc(1);
    end
    cyc(20);
    chk(64'(exp_q.size()), 0, "R5 all deadlines fired once");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule